// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block produces the control lines for each step of a small accumulator processor. A step counter, together with the opcode held in the external instruction register, selects one entry of a microcode store. The store behaves like a wired-AND bus of 32 lines. Every line rests at logic 1, and the selected entry pulls its programmed lines to 0. The datapath reads the raw active-low lines. Three bus drivers can never be on together, so they share one 2-bit field, and the block decodes that field into one-hot enables.

The block has one state register, the step counter. In state `step = 0` it presents the common fetch entry. In states `step = 1 .. L-1` it presents the execute entries of the current opcode. There are two transitions. *Advance* moves from step s to step s+1. *Restart* returns from the last occupied step to step 0. Restart happens when the entry that would come next is the instruction's final entry, which is the only entry that pulls the step-reset line low. The counter acts on that line at the moment the final entry would be selected, so the final entry never takes up a cycle. A system reset, active low, clears the counter at once without waiting for a clock edge.

Top module: `useq_ctrl`

## Requirements
- R1: `ctl_n` carries 32 active-low lines that rest at 1. A line reads 0 only when the current entry programs it. Lines 9 and 13..31 are never programmed and always read 1.
- R2: While `rst_n` is low, `step` is 0 at once, with no clock edge needed, and `ctl_n` shows the fetch entry.
- R3: At step 0, for every opcode, the fetch entry is on `ctl_n`: lines 0 (pointer advance), 1 (memory to bus) and 2 (bus to instruction register) are low and all others are high.
- R4: On each rising clock edge, `step` moves up by one while the current opcode has further execute entries.
- R5: Line 12 is step reset, active low. Only the final entry of an instruction programs it. On the edge that would select the final entry, `step` returns to 0, so line 12 never reads 0 on `ctl_n`. An instruction occupies L cycles including fetch.
- R6: Bits 11:10 of the word form a driver field {bit11,bit10}. Code 00 enables the ALU driver (`drv_sel[0]`), 01 the A-high driver (`drv_sel[1]`), 10 the D-high driver (`drv_sel[2]`), and 11 no driver. At most one bit of `drv_sel` is set in any cycle.
- R7: Load immediate (opcode 0x40, L=3) runs as follows. Step 1 pulls lines 1 (memory to bus) and 3 (bus to A). Step 2 pulls line 0 (pointer advance).
- R8: The register moves (L=2) pull two lines at step 1. Opcode 0x10 pulls 8 (A to bus) and 4 (bus to U). Opcode 0x11 pulls 8 and 5 (bus to V). Opcode 0x12 pulls 6 (U to bus) and 3. Opcode 0x13 pulls 7 (V to bus) and 3.
- R9: The driver opcodes (L=2) set the field at step 1. Opcode 0x20 sets code 00 and pulls line 3. Opcode 0x21 sets code 01 and pulls line 4. Opcode 0x22 sets code 10 and pulls line 5.
- R10: Every other opcode has only the fetch entry (L=1), and `step` stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the step counter moves on its rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ir_byte | input | 8 | Opcode from the instruction register |
| ctl_n | output | 32 | Active-low control lines of the current entry |
| drv_sel | output | 3 | One-hot bus-driver enables decoded from bits 11:10 |
| step | output | 4 | Current step index |

## Verification
`step` changes one register stage after the rising edge, and `ctl_n` and `drv_sel` follow it through combinational logic in the same cycle. Every check therefore samples just after the falling edge, once all of these values have settled. The bench sweeps all 256 opcodes. For each one it holds the opcode, releases reset, and walks L+2 cycles, so the restart to fetch is seen on the exact edge where L cycles have passed. For the reset checks, `rst_n` is dropped between edges and the outputs are read 1 ns later, with no clock edge in between.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int CTL_W  = 32;
    localparam int OP_W   = 8;
    localparam int STEP_W = 4;
    localparam int DRV_N  = 3;

    // line positions inside the control word (active low)
    localparam int B_PC_INC   = 0;
    localparam int B_MEM_OUT  = 1;
    localparam int B_IR_LOAD  = 2;
    localparam int B_A_LOAD   = 3;
    localparam int B_U_LOAD   = 4;
    localparam int B_V_LOAD   = 5;
    localparam int B_U_OUT    = 6;
    localparam int B_V_OUT    = 7;
    localparam int B_A_OUT    = 8;
    localparam int B_DRV_LO   = 10;
    localparam int DRV_CODE_W = 2;
    localparam int B_STEP_RST = 12;

    typedef enum logic [DRV_CODE_W-1:0] {
        DRV_ALU  = 2'b00,
        DRV_AHI  = 2'b01,
        DRV_DHI  = 2'b10,
        DRV_NONE = 2'b11
    } drv_code_e;

    // number of occupied steps (fetch included) for an opcode
    function automatic int unsigned uc_len(input logic [OP_W-1:0] op);
        int unsigned n;
        n = 1;
        if (op == 8'h40) n = 3;
        else if (op inside {8'h10, 8'h11, 8'h12, 8'h13, 8'h20, 8'h21, 8'h22}) n = 2;
        return n;
    endfunction

    // microcode entry: start from an idle-high word and pull lines low
    function automatic logic [CTL_W-1:0] uc_entry(input logic [OP_W-1:0] op,
                                                  input logic [STEP_W-1:0] stp);
        logic [CTL_W-1:0] w;
        w = '1;
        if (stp == '0) begin
            w[B_PC_INC]  = 1'b0;
            w[B_MEM_OUT] = 1'b0;
            w[B_IR_LOAD] = 1'b0;
        end else if (32'(stp) == uc_len(op)) begin
            w[B_STEP_RST] = 1'b0;
        end else if (stp == STEP_W'(1)) begin
            case (op)
                8'h40: begin w[B_MEM_OUT] = 1'b0; w[B_A_LOAD] = 1'b0; end
                8'h10: begin w[B_A_OUT] = 1'b0; w[B_U_LOAD] = 1'b0; end
                8'h11: begin w[B_A_OUT] = 1'b0; w[B_V_LOAD] = 1'b0; end
                8'h12: begin w[B_U_OUT] = 1'b0; w[B_A_LOAD] = 1'b0; end
                8'h13: begin w[B_V_OUT] = 1'b0; w[B_A_LOAD] = 1'b0; end
                8'h20: begin w[B_DRV_LO +: DRV_CODE_W] = DRV_ALU; w[B_A_LOAD] = 1'b0; end
                8'h21: begin w[B_DRV_LO +: DRV_CODE_W] = DRV_AHI; w[B_U_LOAD] = 1'b0; end
                8'h22: begin w[B_DRV_LO +: DRV_CODE_W] = DRV_DHI; w[B_V_LOAD] = 1'b0; end
                default: ;
            endcase
        end else if (stp == STEP_W'(2) && op == 8'h40) begin
            w[B_PC_INC] = 1'b0;
        end
        return w;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int W_OP   = OP_W,
    parameter int W_STEP = STEP_W,
    parameter int W_CTL  = CTL_W
) (
    input  logic [W_OP-1:0]   op,
    input  logic [W_STEP-1:0] stp,
    output logic [W_CTL-1:0]  word
);

    always_comb begin
        word = uc_entry(op, stp);
    end

endmodule

// File: rtl/useq_drv_dec.sv
module useq_drv_dec #(
    parameter int N_DRV = 3,
    localparam int CODE_W = $clog2(N_DRV + 1)
) (
    input  logic [CODE_W-1:0] code,
    output logic [N_DRV-1:0]  en
);

    for (genvar i = 0; i < N_DRV; i++) begin : g_dec
        assign en[i] = (code == CODE_W'(i));
    end

endmodule

// File: rtl/useq_step_ctr.sv
module useq_step_ctr #(
    parameter int W_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              end_next,
    output logic [W_STEP-1:0] step_q
);

    typedef enum logic {MV_ADVANCE, MV_RESTART} move_e;

    move_e             move;
    logic [W_STEP-1:0] step_d;

    always_comb begin
        move = end_next ? MV_RESTART : MV_ADVANCE;
        unique case (move)
            MV_ADVANCE: step_d = step_q + 1'b1;
            MV_RESTART: step_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

    // R4: a non-zero step can only be reached by advancing from the one below
    p_step_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != '0) |-> (step_q == $past(step_q) + 1'b1));

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   ir_byte,
    output logic [CTL_W-1:0]  ctl_n,
    output logic [DRV_N-1:0]  drv_sel,
    output logic [STEP_W-1:0] step
);

    logic [CTL_W-1:0]  cur_word;
    logic [CTL_W-1:0]  ahead_word;
    logic [STEP_W-1:0] step_ahead;

    assign step_ahead = step + 1'b1;

    useq_step_ctr #(.W_STEP(STEP_W)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .end_next (~ahead_word[B_STEP_RST]),
        .step_q   (step)
    );

    useq_store #(.W_OP(OP_W), .W_STEP(STEP_W), .W_CTL(CTL_W)) i_cur (
        .op   (ir_byte),
        .stp  (step),
        .word (cur_word)
    );

    useq_store #(.W_OP(OP_W), .W_STEP(STEP_W), .W_CTL(CTL_W)) i_ahead (
        .op   (ir_byte),
        .stp  (step_ahead),
        .word (ahead_word)
    );

    useq_drv_dec #(.N_DRV(DRV_N)) i_dec (
        .code (ctl_n[B_DRV_LO +: DRV_CODE_W]),
        .en   (drv_sel)
    );

    always_comb begin
        ctl_n = cur_word;
    end

    // R6: never more than one bus driver
    p_drv_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_sel));

    // R5: the final entry is never presented on the lines
    p_end_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_n[B_STEP_RST]);

    // R3: step 0 always presents the fetch lines
    p_fetch_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0) |-> (ctl_n[2:0] == 3'b000));

endmodule

// File: tb/test_useq_ctrl.sv
`timescale 1ns/1ps
module test_useq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ir_byte = 8'h00;
    logic [31:0] ctl_n;
    logic [2:0]  drv_sel;
    logic [3:0]  step;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    useq_ctrl i_useq_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ir_byte (ir_byte),
        .ctl_n   (ctl_n),
        .drv_sel (drv_sel),
        .step    (step)
    );

    function automatic int exp_len(input int op);
        if (op == 'h40) return 3;
        if ((op >= 'h10 && op <= 'h13) || (op >= 'h20 && op <= 'h22)) return 2;
        return 1;
    endfunction

    function automatic logic [31:0] clr(input logic [31:0] w, input int a, input int b);
        logic [31:0] r;
        r = w;
        r[a] = 1'b0;
        r[b] = 1'b0;
        return r;
    endfunction

    function automatic logic [31:0] exp_word(input int op, input int s);
        logic [31:0] w;
        w = 32'hFFFF_FFFF;
        if (s == 0) return clr(clr(w, 0, 1), 2, 2);
        if (op == 'h40 && s == 1) return clr(w, 1, 3);
        if (op == 'h40 && s == 2) return clr(w, 0, 0);
        if (s != 1) return w;
        case (op)
            'h10: w = clr(w, 8, 4);
            'h11: w = clr(w, 8, 5);
            'h12: w = clr(w, 6, 3);
            'h13: w = clr(w, 7, 3);
            'h20: w = clr(clr(w, 10, 11), 3, 3);
            'h21: w = clr(w, 11, 4);
            'h22: w = clr(w, 10, 5);
            default: ;
        endcase
        return w;
    endfunction

    function automatic logic [2:0] exp_drv(input int op, input int s);
        if (s != 1) return 3'b000;
        if (op == 'h20) return 3'b001;
        if (op == 'h21) return 3'b010;
        if (op == 'h22) return 3'b100;
        return 3'b000;
    endfunction

    function automatic string word_tag(input int op, input int s);
        if (s == 0) return "R3";
        if (op == 'h40) return "R7";
        if (op >= 'h10 && op <= 'h13) return "R8";
        if (op >= 'h20 && op <= 'h22) return "R9";
        return "R10";
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: op=%02h actual=%08h expected=%08h", tag, ir_byte, act, exp);
        end
    endtask

    task automatic run_op(input int op);
        int len;
        int s;
        len = exp_len(op);
        @(negedge clk);
        ir_byte = 8'(op);
        rst_n = 1'b0;
        #1;
        check(step == 4'd0, "R2", 32'(step), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int k = 0; k <= len + 1; k++) begin
            s = k % len;
            check(step == 4'(s), (s == 0 && k > 0) ? "R5" : "R4", 32'(step), 32'(s));
            check(ctl_n == exp_word(op, s), word_tag(op, s), ctl_n, exp_word(op, s));
            check(ctl_n[12], "R5", 32'(ctl_n[12]), 32'd1);
            check((ctl_n[31:13] == '1) && ctl_n[9], "R1", ctl_n, 32'hFFFF_E200 | ctl_n);
            check(drv_sel == exp_drv(op, s), "R6", 32'(drv_sel), 32'(exp_drv(op, s)));
            check($countones(drv_sel) <= 1, "R6", 32'(drv_sel), 32'd0);
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #2;
        check(step == 4'd0, "R2", 32'(step), 32'd0);
        for (int op = 0; op < 256; op++) begin
            run_op(op);
        end
        // R2: asynchronous clear in the middle of load immediate
        @(negedge clk);
        ir_byte = 8'h40;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(step == 4'd1, "R4", 32'(step), 32'd1);
        rst_n = 1'b0;
        #1;
        check(step == 4'd0, "R2", 32'(step), 32'd0);
        check(ctl_n == exp_word('h40, 0), "R2", ctl_n, exp_word('h40, 0));
        #1;
        rst_n = 1'b1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule